// File: doc/BRIEF.md
# Encoded-Level Interrupt Priority Controller

This block chooses which interrupt a processor core should take next. It looks at three kinds of request. The first is a single non-maskable request. The second is a four-wire, active-low encoded level from off-chip. The third is a bank of on-chip peripheral request lines. Each on-chip line has a priority and a vector that software writes through a small write-only configuration port. The strongest request is compared against the core's current mask level. If it is allowed through, the block raises a request to the core with a level. When the core acknowledges, the block latches the accepted level and vector number and holds them for the core to read.

For the off-chip encoded requests, the vector is either derived from the level (auto-vector) or taken from an external vector bus at the moment of acknowledge. A single mode bit chooses between the two. The off-chip code passes through a two-stage synchroniser before arbitration. All outputs to the core are registered.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0, `ack_level_o` is 0 and `ack_vec_o` is 0. Every on-chip source has priority 0, and the vector mode is auto.
- R2: `irl_n_i` is active low, and its level is the bitwise inverse of the pins, so `4'hF` means no request. A change on the pins reaches `irq_o` on the third rising clock edge after it is applied: two synchroniser stages plus the output register.
- R3: A configuration write with `cfg_addr_i` below NSRC sets that source's priority from `cfg_wdata_i[3:0]` and its vector from `cfg_wdata_i[15:8]`. An on-chip source with priority 0 never produces a request.
- R4: A maskable request is presented only when its level is strictly greater than `mask_i`. `irq_o` follows a change of on-chip requests or of the mask one clock edge later.
- R5: The highest level wins. Among on-chip sources of equal priority, the lowest index wins. An off-chip encoded request beats an on-chip source of the same level.
- R6: A rising edge on `nmi_i` makes a pending non-maskable request. It ignores `mask_i`, beats every other source, and is presented as level 15 with vector NMI_VEC (default 11). Only its own acknowledge clears it, so a held-high `nmi_i` does not request again.
- R7: An on-chip winner supplies its programmed vector. An off-chip winner supplies AUTO_BASE + level (default base 64) when the mode bit is 0. When the mode bit is 1, it supplies the value on `ext_vec_i` at acknowledge. The mode bit is written at address 31, from `cfg_wdata_i[0]`.
- R8: When `ack_i` is high while `irq_o` is high, the presented level and vector are copied to `ack_level_o`/`ack_vec_o` on that edge, and `irq_o` is low for the next cycle. The copied values stay unchanged until the next accepted acknowledge. `ack_i` while `irq_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, rising edge sensitive |
| irl_n_i | input | 4 | Active-low encoded off-chip level |
| int_req_i | input | NSRC | On-chip source request lines |
| mask_i | input | 4 | Core's current interrupt mask level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address (source index, or 31 for mode) |
| cfg_wdata_i | input | 16 | Configuration write data |
| ext_vec_i | input | VW | Externally supplied vector for off-chip requests |
| ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Request to the core |
| irq_level_o | output | 4 | Level of the presented request |
| ack_level_o | output | 4 | Level accepted at the last acknowledge |
| ack_vec_o | output | VW | Vector accepted at the last acknowledge |

## Verification
The hardest case to reach is a tie between an off-chip code and an on-chip source at the same level. The off-chip side only enters arbitration after its synchroniser, so the stimulus holds both requests for several cycles before sampling. It then acknowledges, so the vector shows which side won. The edge-only clearing of the non-maskable request is the other case. It is reached by keeping `nmi_i` high across its acknowledge and checking that no second request appears. A second case is a non-maskable request raised on top of a level-15 off-chip code, followed by acknowledging both in turn.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC      = 12,
  parameter int AW        = 5,
  parameter int VW        = 8,
  parameter int NMI_VEC   = 11,
  parameter int AUTO_BASE = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic [3:0]      irl_n_i,
  input  logic [NSRC-1:0] int_req_i,
  input  logic [3:0]      mask_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [15:0]     cfg_wdata_i,
  input  logic [VW-1:0]   ext_vec_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [3:0]      irq_level_o,
  output logic [3:0]      ack_level_o,
  output logic [VW-1:0]   ack_vec_o
);
  localparam int LW = 4;
  localparam logic [AW-1:0] MODE_ADDR = '1;
  localparam logic [LW-1:0] TOP_LVL = '1;

  logic [LW-1:0] prio_q [NSRC];
  logic [VW-1:0] vec_q  [NSRC];
  logic          ext_mode_q;
  logic [LW-1:0] irl_s1, irl_s2;
  logic          nmi_q, nmi_pend;
  logic          pres_nmi, pres_ext;
  logic [VW-1:0] pres_vec;
  logic [LW-1:0] best_lvl;
  logic [VW-1:0] best_vec;
  logic          best_int;
  logic          win_valid, accept;

  assign accept    = ack_i & irq_o;
  assign win_valid = nmi_pend | (best_lvl > mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
      end
      ext_mode_q <= 1'b0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == MODE_ADDR) ext_mode_q <= cfg_wdata_i[0];
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_addr_i == AW'(i)) begin
          prio_q[i] <= cfg_wdata_i[LW-1:0];
          vec_q[i]  <= cfg_wdata_i[8 +: VW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irl_s1   <= '0;
      irl_s2   <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      irl_s1   <= ~irl_n_i;
      irl_s2   <= irl_s1;
      nmi_q    <= nmi_i;
      nmi_pend <= (nmi_i & ~nmi_q) | (nmi_pend & ~(accept & pres_nmi));
    end
  end

  always_comb begin
    best_lvl = irl_s2;
    best_vec = VW'(AUTO_BASE) + VW'(irl_s2);
    best_int = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (int_req_i[i] && prio_q[i] > best_lvl) begin
        best_lvl = prio_q[i];
        best_vec = vec_q[i];
        best_int = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      irq_level_o <= '0;
      pres_vec    <= '0;
      pres_nmi    <= 1'b0;
      pres_ext    <= 1'b0;
      ack_level_o <= '0;
      ack_vec_o   <= '0;
    end else begin
      irq_o       <= win_valid & ~accept;
      irq_level_o <= nmi_pend ? TOP_LVL : best_lvl;
      pres_vec    <= nmi_pend ? VW'(NMI_VEC) : best_vec;
      pres_nmi    <= nmi_pend;
      pres_ext    <= ~nmi_pend & ~best_int & ext_mode_q;
      if (accept) begin
        ack_level_o <= irq_level_o;
        ack_vec_o   <= pres_ext ? ext_vec_i : pres_vec;
      end
    end
  end

  a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(ack_level_o) && $stable(ack_vec_o)));

  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_o);

  a_r4_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !pres_nmi) |-> (irq_level_o > $past(mask_i)));

  a_r6_nmi_served: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !accept) |=> (irq_o && irq_level_o == TOP_LVL));

  a_r5_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_level_o != '0));
endmodule

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
  localparam int NSRC = 12;
  logic clk = 1'b0, rst_n = 1'b0, nmi_i = 1'b0, cfg_we_i = 1'b0, ack_i = 1'b0;
  logic [3:0] irl_n_i = 4'hF, mask_i = 4'd0;
  logic [NSRC-1:0] int_req_i = '0;
  logic [4:0] cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [7:0] ext_vec_i = '0;
  logic irq_o;
  logic [3:0] irq_level_o, ack_level_o;
  logic [7:0] ack_vec_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  irq_level_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .irl_n_i(irl_n_i), .int_req_i(int_req_i),
    .mask_i(mask_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .ext_vec_i(ext_vec_i), .ack_i(ack_i), .irq_o(irq_o), .irq_level_o(irq_level_o),
    .ack_level_o(ack_level_o), .ack_vec_o(ack_vec_o));

  always #4 clk = ~clk;

  // {irl_n(4), int_req(12), mask(4), exp_irq(1), exp_lvl(4), exp_vec(8)}
  localparam bit [32:0] TBL [13] = '{
    {4'hF, 12'h000, 4'd0,  1'b0, 4'd0,  8'd0},
    {4'hF, 12'h001, 4'd0,  1'b1, 4'd3,  8'd100},
    {4'hF, 12'h003, 4'd0,  1'b1, 4'd3,  8'd100},
    {4'hF, 12'h001, 4'd3,  1'b0, 4'd0,  8'd0},
    {4'hF, 12'h001, 4'd2,  1'b1, 4'd3,  8'd100},
    {4'hF, 12'h008, 4'd0,  1'b0, 4'd0,  8'd0},
    {4'hF, 12'h014, 4'd0,  1'b1, 4'd12, 8'd104},
    {4'hA, 12'h010, 4'd0,  1'b1, 4'd12, 8'd104},
    {4'h3, 12'h010, 4'd0,  1'b1, 4'd12, 8'd76},
    {4'h0, 12'h000, 4'd14, 1'b1, 4'd15, 8'd79},
    {4'h0, 12'h000, 4'd15, 1'b0, 4'd0,  8'd0},
    {4'hF, 12'h800, 4'd10, 1'b1, 4'd11, 8'd111},
    {4'h6, 12'h004, 4'd8,  1'b1, 4'd9,  8'd73}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    cfg_we_i = 1'b1; cfg_addr_i = 5'(addr); cfg_wdata_i = 16'(data);
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1;
    tick(1);
    ack_i = 1'b0;
  endtask

  function automatic int prio_of(int i);
    if (i == 0 || i == 1) return 3;
    if (i == 2) return 7;
    if (i == 3) return 0;
    if (i == 4) return 12;
    return i;
  endfunction

  initial begin
    tick(3);
    chk("R1 reset irq", int'(irq_o), 0);
    chk("R1 reset ack level", int'(ack_level_o), 0);
    chk("R1 reset ack vec", int'(ack_vec_o), 0);
    rst_n = 1'b1;
    tick(1);
    for (int i = 0; i < NSRC; i++) wr(i, ((100 + i) << 8) | prio_of(i));
    tick(2);

    for (int k = 0; k < 13; k++) begin
      irl_n_i = TBL[k][32:29]; int_req_i = TBL[k][28:17]; mask_i = TBL[k][16:13];
      tick(4);
      chk($sformatf("R3 R4 R5 row %0d irq", k), int'(irq_o), int'(TBL[k][12]));
      if (TBL[k][12]) begin
        chk($sformatf("R5 row %0d level", k), int'(irq_level_o), int'(TBL[k][11:8]));
        ack_pulse();
        chk($sformatf("R8 row %0d ack level", k), int'(ack_level_o), int'(TBL[k][11:8]));
        chk($sformatf("R7 row %0d ack vec", k), int'(ack_vec_o), int'(TBL[k][7:0]));
        chk($sformatf("R8 row %0d drop", k), int'(irq_o), 0);
      end
    end

    // R2 synchroniser latency
    irl_n_i = 4'hF; int_req_i = '0; mask_i = 4'd0;
    tick(4);
    irl_n_i = 4'h9;
    tick(2);
    chk("R2 irq not yet after two edges", int'(irq_o), 0);
    tick(1);
    chk("R2 irq on third edge", int'(irq_o), 1);
    chk("R2 level decode", int'(irq_level_o), 6);

    // R7 external vector mode, R8 hold
    wr(31, 1);
    ext_vec_i = 8'hC3;
    tick(2);
    ack_pulse();
    chk("R7 external vector", int'(ack_vec_o), 8'hC3);
    chk("R7 external level", int'(ack_level_o), 6);
    ext_vec_i = 8'h5A;
    tick(3);
    chk("R8 vector held", int'(ack_vec_o), 8'hC3);
    irl_n_i = 4'hF;
    tick(4);
    ack_pulse();
    tick(1);
    chk("R8 ignored ack level", int'(ack_level_o), 6);
    chk("R8 ignored ack vec", int'(ack_vec_o), 8'hC3);

    // R6 non-maskable
    mask_i = 4'd15;
    nmi_i = 1'b1;
    tick(3);
    chk("R6 nmi beats mask", int'(irq_o), 1);
    chk("R6 nmi level", int'(irq_level_o), 15);
    ack_pulse();
    chk("R6 nmi vector", int'(ack_vec_o), 11);
    tick(3);
    chk("R6 held nmi no re-request", int'(irq_o), 0);
    nmi_i = 1'b0;
    mask_i = 4'd0;
    irl_n_i = 4'h0;
    tick(4);
    nmi_i = 1'b1;
    tick(3);
    ack_pulse();
    chk("R6 nmi beats level 15", int'(ack_vec_o), 11);
    nmi_i = 1'b0;
    tick(3);
    ack_pulse();
    chk("R7 level 15 external vector after nmi", int'(ack_vec_o), 8'h5A);
    chk("R5 level 15 accepted", int'(ack_level_o), 15);
    wr(31, 0);
    irl_n_i = 4'hF;

    // R3 disable via write
    wr(4, (104 << 8) | 0);
    int_req_i = 12'h010;
    tick(4);
    chk("R3 priority zero disabled", int'(irq_o), 0);
    wr(4, (104 << 8) | 5);
    tick(2);
    chk("R3 re-enabled irq", int'(irq_o), 1);
    chk("R3 re-enabled level", int'(irq_level_o), 5);
    mask_i = 4'd5;
    tick(1);
    chk("R4 mask raise drops in one edge", int'(irq_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule